// File: doc/BRIEF.md
# Trigger-Latency Sample Buffer with Event Readout

The block sits behind five digitiser channels on the bunch clock. Every cycle it takes one 14-bit word from each channel and writes it into a circular store. Each word holds a 2-bit gain code in bits 13:12 and a 12-bit ADC code in bits 11:0. The store keeps running without pause, so history older than the level-1 decision time is always available.

When a level-1 accept arrives, the block records where the wanted window begins. That point is the current write position minus a programmable latency. It also records the current bunch number and a running event number, and queues the record. A fragment builder serves queued records in order. For each record it sends one header word, the ten-sample window of every channel, and one trailer word on a 16-bit bus. Capture continues at full rate while a fragment is being sent. Up to four accepts can wait in the queue. When all four slots are taken, a busy flag rises and any further accepts are discarded.

Top module: `lat_event_buf`

## Requirements
- R1: On every clock after reset, the five channel words on `sample_i` are stored (channel c at bits 14c+13:14c), including while a fragment is being sent.
- R2: An accept sampled with bunch number b and latency L (0 to 255) sends the samples captured at bunch numbers b-L through b-L+9, oldest first.
- R3: A fragment is 52 words on consecutive cycles: header, then the 10 samples of channel 0, then channel 1 and so on to channel 4, then trailer. When the builder is idle, the header appears two clock edges after the edge that sampled the accept.
- R4: Header bits 11:0 hold the bunch number at the accept. Bits 15:12 hold the event number modulo 16, which counts retained accepts from 0 after reset.
- R5: Each sample word carries the stored 14-bit word in bits 13:0, and bits 15:14 are zero.
- R6: The trailer word equals 52, the total number of words in the fragment.
- R7: Without an accept, `evt_valid_o` stays low.
- R8: Accepts are queued up to 4 deep and served in arrival order. Each fragment is followed by exactly one cycle with `evt_valid_o` low before the next header.
- R9: `busy_o` is high while 4 accepts are waiting. An accept that arrives while busy is discarded and does not advance the event number.
- R10: After reset, `evt_valid_o` and `busy_o` are low, and the first clock edge after reset is bunch number 0.
- R11: `evt_sof_o` is high only with the header word, and `evt_last_o` is high only with the trailer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 70 | Five 14-bit channel words, channel 0 in the low bits |
| latency_i | input | 8 | Trigger latency in cycles |
| l1a_i | input | 1 | Level-1 accept |
| evt_o | output | 16 | Fragment word |
| evt_valid_o | output | 1 | Fragment word valid |
| evt_sof_o | output | 1 | Header word marker |
| evt_last_o | output | 1 | Trailer word marker |
| busy_o | output | 1 | Accept queue full |

## Verification
The bench drives a sample pattern that changes every cycle, so each output word shows exactly which bunch it came from. This makes it visible whether writes into the ring during readout disturb the window being read. Accepts are also fired on consecutive cycles. The second accept is pushed into the queue on the same edge that the builder pops the first. The bench checks that three fragments follow 53 cycles apart, with consecutive event numbers and the right windows. A seven-accept burst overfills the queue. There the bench checks `busy_o`, confirms that exactly five fragments appear, and confirms that the next event number skips nothing.

// File: rtl/evbuf_pkg.sv
package evbuf_pkg;
  localparam int unsigned DEF_NCH    = 5;
  localparam int unsigned DEF_SW     = 14;
  localparam int unsigned DEF_WIN    = 10;
  localparam int unsigned DEF_RING_AW = 10;
  localparam int unsigned DEF_LAT_W  = 8;
  localparam int unsigned DEF_BC_W   = 12;
  localparam int unsigned DEF_EVN_W  = 4;
  localparam int unsigned DEF_TQ_DEPTH = 4;
  localparam int unsigned DEF_OUT_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_TRL
  } frag_state_e;
endpackage

// File: rtl/sample_ring.sv
module sample_ring #(
  parameter int unsigned NCH = 5,
  parameter int unsigned SW  = 14,
  parameter int unsigned AW  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH*SW-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [AW-1:0]     wr_ptr_o,
  output logic [NCH*SW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 2**AW;

  logic [AW-1:0] wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_ptr_q <= '0;
    else         wr_ptr_q <= wr_ptr_q + 1'b1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic [SW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      mem[wr_ptr_q] <= wr_data_i[ch*SW +: SW];
    end
    assign rd_data_o[ch*SW +: SW] = mem[rd_addr_i];
  end

  assign wr_ptr_o = wr_ptr_q;
endmodule

// File: rtl/trig_queue.sv
module trig_queue #(
  parameter int unsigned W     = 26,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = slot_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) slot_q[wp_q] <= data_i;
  end

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (cnt_q == $past(cnt_q))); // R9
  AST_POP_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R8
endmodule

// File: rtl/frag_builder.sv
module frag_builder
  import evbuf_pkg::*;
#(
  parameter int unsigned NCH   = 5,
  parameter int unsigned SW    = 14,
  parameter int unsigned WIN   = 10,
  parameter int unsigned AW    = 10,
  parameter int unsigned BC_W  = 12,
  parameter int unsigned EVN_W = 4,
  parameter int unsigned OUT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_valid_i,
  input  logic [AW-1:0]     trig_start_i,
  input  logic [BC_W-1:0]   trig_bc_i,
  input  logic [EVN_W-1:0]  trig_evn_i,
  output logic              trig_pop_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [NCH*SW-1:0] rd_data_i,
  output logic [OUT_W-1:0]  evt_o,
  output logic              evt_valid_o,
  output logic              evt_sof_o,
  output logic              evt_last_o
);
  localparam int unsigned CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned SMP_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int unsigned FRAG_WORDS = NCH * WIN + 2;

  frag_state_e      state_q;
  logic [AW-1:0]    base_q;
  logic [BC_W-1:0]  bc_q;
  logic [EVN_W-1:0] evn_q;
  logic [CH_W-1:0]  ch_q;
  logic [SMP_W-1:0] smp_q;

  assign trig_pop_o = (state_q == ST_IDLE) && trig_valid_i;
  assign rd_addr_o  = base_q + AW'(smp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      bc_q    <= '0;
      evn_q   <= '0;
      ch_q    <= '0;
      smp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (trig_valid_i) begin
          base_q  <= trig_start_i;
          bc_q    <= trig_bc_i;
          evn_q   <= trig_evn_i;
          state_q <= ST_HDR;
        end
        ST_HDR: begin
          ch_q    <= '0;
          smp_q   <= '0;
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (smp_q == SMP_W'(WIN - 1)) begin
            smp_q <= '0;
            if (ch_q == CH_W'(NCH - 1)) state_q <= ST_TRL;
            else                        ch_q    <= ch_q + 1'b1;
          end else begin
            smp_q <= smp_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    evt_o       = '0;
    evt_valid_o = 1'b0;
    evt_sof_o   = 1'b0;
    evt_last_o  = 1'b0;
    unique case (state_q)
      ST_HDR: begin
        evt_valid_o = 1'b1;
        evt_sof_o   = 1'b1;
        evt_o       = OUT_W'({evn_q, bc_q});
      end
      ST_DATA: begin
        evt_valid_o = 1'b1;
        evt_o       = OUT_W'(rd_data_i[int'(ch_q)*SW +: SW]);
      end
      ST_TRL: begin
        evt_valid_o = 1'b1;
        evt_last_o  = 1'b1;
        evt_o       = OUT_W'(FRAG_WORDS);
      end
      default: ;
    endcase
  end

  AST_HDR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_valid_o) |-> evt_sof_o); // R11
  AST_HDR_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_sof_o |=> (evt_valid_o && !evt_sof_o)); // R3
  AST_GAP_AFTER_TRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_last_o |=> !evt_valid_o); // R8
endmodule

// File: rtl/lat_event_buf.sv
module lat_event_buf
  import evbuf_pkg::*;
#(
  parameter int unsigned NCH      = DEF_NCH,
  parameter int unsigned SW       = DEF_SW,
  parameter int unsigned WIN      = DEF_WIN,
  parameter int unsigned RING_AW  = DEF_RING_AW,
  parameter int unsigned LAT_W    = DEF_LAT_W,
  parameter int unsigned BC_W     = DEF_BC_W,
  parameter int unsigned EVN_W    = DEF_EVN_W,
  parameter int unsigned TQ_DEPTH = DEF_TQ_DEPTH,
  parameter int unsigned OUT_W    = DEF_OUT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH*SW-1:0] sample_i,
  input  logic [LAT_W-1:0]  latency_i,
  input  logic              l1a_i,
  output logic [OUT_W-1:0]  evt_o,
  output logic              evt_valid_o,
  output logic              evt_sof_o,
  output logic              evt_last_o,
  output logic              busy_o
);
  localparam int unsigned ENT_W = RING_AW + BC_W + EVN_W;

  logic [BC_W-1:0]    bc_cnt_q;
  logic [EVN_W-1:0]   evn_cnt_q;
  logic [RING_AW-1:0] wr_ptr, rd_addr, win_start;
  logic [NCH*SW-1:0]  rd_data;
  logic [ENT_W-1:0]   q_in, q_out;
  logic               q_empty, q_full, q_pop, q_push;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bc_cnt_q  <= '0;
      evn_cnt_q <= '0;
    end else begin
      bc_cnt_q <= bc_cnt_q + 1'b1;
      if (q_push) evn_cnt_q <= evn_cnt_q + 1'b1;
    end
  end

  sample_ring #(.NCH(NCH), .SW(SW), .AW(RING_AW)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_data_i (sample_i),
    .rd_addr_i (rd_addr),
    .wr_ptr_o  (wr_ptr),
    .rd_data_o (rd_data)
  );

  // window origin is fixed when the accept is taken
  assign win_start = wr_ptr - RING_AW'(latency_i);
  assign q_push    = l1a_i && !q_full;
  assign q_in      = {win_start, bc_cnt_q, evn_cnt_q};

  trig_queue #(.W(ENT_W), .DEPTH(TQ_DEPTH)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (l1a_i),
    .data_i  (q_in),
    .pop_i   (q_pop),
    .data_o  (q_out),
    .empty_o (q_empty),
    .full_o  (q_full)
  );

  frag_builder #(
    .NCH(NCH), .SW(SW), .WIN(WIN), .AW(RING_AW),
    .BC_W(BC_W), .EVN_W(EVN_W), .OUT_W(OUT_W)
  ) u_build (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_valid_i (!q_empty),
    .trig_start_i (q_out[ENT_W-1 -: RING_AW]),
    .trig_bc_i    (q_out[EVN_W +: BC_W]),
    .trig_evn_i   (q_out[EVN_W-1:0]),
    .trig_pop_o   (q_pop),
    .rd_addr_o    (rd_addr),
    .rd_data_i    (rd_data),
    .evt_o        (evt_o),
    .evt_valid_o  (evt_valid_o),
    .evt_sof_o    (evt_sof_o),
    .evt_last_o   (evt_last_o)
  );

  assign busy_o = q_full;

  AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(l1a_i)); // R9
  AST_QUIET_NO_TRIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!evt_valid_o && q_empty && !l1a_i) |=> !evt_valid_o); // R7
endmodule

// File: tb/lat_event_buf_bench.sv
`timescale 1ns/1ps
module lat_event_buf_bench;
  localparam int NCH = 5;
  localparam int SW  = 14;
  localparam int FW  = 52;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NCH*SW-1:0] sample_i = '0;
  logic [7:0]        latency_i = '0;
  logic              l1a_i = 1'b0;
  logic [15:0]       evt_o;
  logic              evt_valid_o, evt_sof_o, evt_last_o, busy_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_evn = 0;
  bit done = 0;

  logic [15:0] cap_w [2048];
  int          cap_c [2048];
  logic [1:0]  cap_f [2048];
  int          cap_n = 0;

  always #2.5 clk = ~clk;

  lat_event_buf u_lat_event_buf (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .latency_i(latency_i),
    .l1a_i(l1a_i), .evt_o(evt_o), .evt_valid_o(evt_valid_o),
    .evt_sof_o(evt_sof_o), .evt_last_o(evt_last_o), .busy_o(busy_o)
  );

  function automatic logic [13:0] smp(int c, int n);
    logic [1:0]  g;
    logic [11:0] a;
    g = 2'((n + c) & 3);
    a = 12'((n * 37 + c * 411) & 12'hFFF);
    return {g, a};
  endfunction

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) sample_i[c*SW +: SW] = smp(c, cyc);
    if (evt_valid_o && cap_n < 2048) begin
      cap_w[cap_n] = evt_o;
      cap_c[cap_n] = cyc;
      cap_f[cap_n] = {evt_sof_o, evt_last_o};
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // fire one accept at the current negedge, return its bunch number
  task automatic fire(output int k);
    @(negedge clk);
    k = cyc;
    l1a_i = 1'b1;
    @(negedge clk);
    l1a_i = 1'b0;
  endtask

  task automatic check_event(int base, int k, int lat, int evn, int t0);
    logic [15:0] e;
    int w;
    chk(cap_n >= base + FW, "R3 fragment length", cap_n - base, FW);
    if (cap_n < base + FW) return;
    chk(cap_c[base] == t0, "R3 header timing", cap_c[base], t0);
    e = {4'(evn), 12'(k)};
    chk(cap_w[base] == e, "R4 header", cap_w[base], e);
    chk(cap_f[base] == 2'b10, "R11 sof marker", cap_f[base], 2);
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < 10; s++) begin
        w = base + 1 + c * 10 + s;
        e = {2'b00, smp(c, k - lat + s)};
        chk(cap_w[w] == e, "R2 R5 sample word", cap_w[w], e);
        chk(cap_c[w] == t0 + 1 + c * 10 + s, "R3 contiguous", cap_c[w], t0 + 1 + c * 10 + s);
      end
    chk(cap_w[base + FW - 1] == 16'(FW), "R6 trailer", cap_w[base + FW - 1], FW);
    chk(cap_f[base + FW - 1] == 2'b01, "R11 last marker", cap_f[base + FW - 1], 1);
  endtask

  task automatic t_reset();
    chk(evt_valid_o == 1'b0, "R10 valid after reset", evt_valid_o, 0);
    chk(busy_o == 1'b0, "R10 busy after reset", busy_o, 0);
    chk(cap_n == 0, "R10 no output", cap_n, 0);
  endtask

  task automatic t_single(int lat);
    int k, base;
    latency_i = 8'(lat);
    idle(2);
    base = cap_n;
    fire(k);
    idle(60);
    check_event(base, k, lat, exp_evn, k + 2);
    exp_evn = (exp_evn + 1) % 16;
    chk(cap_n == base + FW, "R7 one fragment per accept", cap_n - base, FW);
  endtask

  task automatic t_quiet();
    int n0 = cap_n;
    idle(150);
    chk(cap_n == n0, "R7 no accept no output", cap_n - n0, 0);
    chk(evt_valid_o == 1'b0, "R7 valid low", evt_valid_o, 0);
  endtask

  task automatic t_burst();
    int k0, base;
    latency_i = 8'd15;
    idle(2);
    base = cap_n;
    @(negedge clk);
    k0 = cyc;
    l1a_i = 1'b1;
    idle(3);
    l1a_i = 1'b0;
    idle(3 * 53 + 10);
    for (int i = 0; i < 3; i++) begin
      check_event(base + i * FW, k0 + i, 15, exp_evn, k0 + 2 + i * 53);
      exp_evn = (exp_evn + 1) % 16;
    end
    chk(cap_n == base + 3 * FW, "R8 three fragments", cap_n - base, 3 * FW);
  endtask

  task automatic t_overflow();
    int k0, base;
    latency_i = 8'd30;
    idle(2);
    base = cap_n;
    @(negedge clk);
    k0 = cyc;
    l1a_i = 1'b1;
    for (int i = 1; i < 7; i++) begin
      @(negedge clk);
      if (i == 5) chk(busy_o == 1'b1, "R9 busy when four wait", busy_o, 1);
      if (i == 4) chk(busy_o == 1'b0, "R9 not busy at three", busy_o, 0);
    end
    l1a_i = 1'b0;
    @(negedge clk);
    chk(busy_o == 1'b1, "R9 busy holds", busy_o, 1);
    idle(5 * 53 + 10);
    chk(busy_o == 1'b0, "R9 busy clears", busy_o, 0);
    chk(cap_n == base + 5 * FW, "R9 extra accepts dropped", (cap_n - base) / FW, 5);
    for (int i = 0; i < 5; i++) begin
      check_event(base + i * FW, k0 + i, 30, exp_evn, k0 + 2 + i * 53);
      exp_evn = (exp_evn + 1) % 16;
    end
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    idle(4);
    t_reset();
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    idle(40);
    t_single(20);        // R1 R2 R3 R4 R5 R6 R11
    t_quiet();           // R7
    t_single(0);         // R2 lower bound
    idle(300);
    t_single(255);       // R2 upper bound
    t_burst();           // R8, capture during readout R1
    t_overflow();        // R9
    t_single(12);        // R9 event number continues
    for (int i = 0; i < 10; i++) t_single(10 + i * 23); // R4 wrap of event number
    finish_run();
  end
endmodule